// File: doc/BRIEF.md
# Two-Word Host Load Buffer

This block sits between a 16-bit host bus and a 32-bit serial transmitter. The host writes one 32-bit word as two 16-bit halves. Each half goes in through a write strobe, and an address select line picks which half the write fills. The block keeps the two halves in a holding register. It raises a full flag toward the serializer once both halves are present, and it holds the word until the serializer acknowledges the transfer.

The strobe is active low and arrives asynchronously. A synchronizer of parameterised depth brings it into the system clock domain, and an edge detector turns each completed low pulse into exactly one load. The ready output tells the host that the holding register can take a new word. Ready falls when the word becomes complete and rises again on the cycle after the serializer takes it.

The host must hold the data and select lines stable from the strobe's rising edge until the load has happened, which takes `SYNC_STAGES + 1` clock edges.

Top module: `two_word_load_buffer`

## Requirements
- R1: A completed write with `host_sel` = 1 stores `host_data` into `word_out[15:0]`, the half that is sent first as serial bits 1 to 16.
- R2: A completed write with `host_sel` = 0 stores `host_data` into `word_out[31:16]`, the half that is sent as serial bits 17 to 32.
- R3: A load happens only after the strobe's rising edge, which ends the low pulse. The load becomes visible at the ports within `SYNC_STAGES + 1` clock edges of that edge. A long low pulse changes nothing while it stays low, and it produces exactly one load.
- R4: While the two halves have not both been written since reset or since the last transfer, `word_full` is 0 and `host_ready` is 1.
- R5: Once both halves have been written since the last transfer, in either order, `word_full` becomes 1 and `host_ready` becomes 0.
- R6: When `take_ack` is 1 while `word_full` is 1, on the next cycle `word_full` is 0 and `host_ready` is 1. Both halves must then be written again before `word_full` rises.
- R7: While `rst_n` is 0, `word_full` is 0, `host_ready` is 1 and `word_out` is all zeros.
- R8: A write that completes while `word_full` is 1 is ignored. `word_out` and `word_full` do not change.
- R9: Writing the same half twice before the other half is written replaces its contents and does not set `word_full`.
- R10: `take_ack` while `word_full` is 0 has no effect on `word_full`, `host_ready` or `word_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_data | input | 16 | Host data bus, one half of the word |
| host_sel | input | 1 | Half select: 1 = low half (first), 0 = high half (second) |
| host_wr_n | input | 1 | Active-low write strobe; data is taken at its rising edge |
| host_ready | output | 1 | High when the holding register can accept a new word |
| word_out | output | 32 | Assembled word; bits 15:0 go out first |
| word_full | output | 1 | Both halves are present and waiting for the serializer |
| take_ack | input | 1 | Serializer has taken the word; frees the holding register |

## Verification
The internal state is two half-valid flags plus the stored data. A wrong flag therefore shows up at `word_full` and `host_ready` within `SYNC_STAGES + 1` edges of the strobe's rise: full rises after only one half has been written, or it fails to rise after both. A load steered to the wrong half, or a write that is not blocked while full, changes the wrong slice of `word_out` in that same window. A stuck or doubled edge detector shows up as data that appears while the strobe is still low, or as no load at all. The checks therefore sample `word_out` both during a long low pulse and after it ends.

// File: rtl/lb_pkg.sv
package lb_pkg;
   // Which half of the holding register a write addresses.
   typedef enum logic {
      HALF_HI = 1'b0,   // select low: second half, serial bits 17..32
      HALF_LO = 1'b1    // select high: first half, serial bits 1..16
   } half_e;

   localparam int unsigned NUM_HALVES = 2;

   function automatic half_e sel_to_half(input logic sel);
      return sel ? HALF_LO : HALF_HI;
   endfunction
endpackage

// File: rtl/lb_strobe_sync.sv
// Brings an asynchronous active-low strobe into the clock domain and
// pulses for one cycle at the end of each low pulse.
module lb_strobe_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic done_pulse
);
   localparam int unsigned CHAIN_W = STAGES + 1;

   logic [CHAIN_W-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("lb_strobe_sync: STAGES must be at least 2");
      end
   endgenerate

   // The chain resets to the idle (high) level so that no edge is seen at reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
      end else begin
         chain_q <= {chain_q[CHAIN_W-2:0], strobe_n};
      end
   end

   // Low-to-high transition after the synchronizing stages.
   assign done_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/lb_half_reg.sv
// One half of the holding register with its own valid flag.
module lb_half_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         clear,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         valid
);
   generate
      if (W < 1) begin : g_bad_width
         $error("lb_half_reg: W must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q     <= '0;
         valid <= 1'b0;
      end else begin
         if (load) begin
            q     <= din;
            valid <= 1'b1;
         end else if (clear) begin
            valid <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/two_word_load_buffer.sv
module two_word_load_buffer #(
   parameter int unsigned HALF_W      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [HALF_W-1:0]   host_data,
   input  logic                host_sel,
   input  logic                host_wr_n,
   output logic                host_ready,
   output logic [2*HALF_W-1:0] word_out,
   output logic                word_full,
   input  logic                take_ack
);
   import lb_pkg::*;

   localparam int unsigned WORD_W = NUM_HALVES * HALF_W;

   logic                  wr_done;
   logic                  full_q;
   logic [NUM_HALVES-1:0] half_valid;
   logic [NUM_HALVES-1:0] half_load;
   logic                  transfer;
   half_e                 target;

   lb_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe_n   (host_wr_n),
      .done_pulse (wr_done)
   );

   assign target   = sel_to_half(host_sel);
   assign transfer = full_q & take_ack;

   // Slot 0 = low half (serial bits 1..16), slot 1 = high half.
   generate
      for (genvar i = 0; i < NUM_HALVES; i++) begin : g_half
         localparam half_e SLOT = (i == 0) ? HALF_LO : HALF_HI;
         assign half_load[i] = wr_done & ~full_q & (target == SLOT);
         lb_half_reg #(.W(HALF_W)) u_half (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (half_load[i]),
            .clear (transfer),
            .din   (host_data),
            .q     (word_out[i*HALF_W +: HALF_W]),
            .valid (half_valid[i])
         );
      end
   endgenerate

   assign full_q     = &half_valid;
   assign word_full  = full_q;
   assign host_ready = ~full_q;

   generate
      if (WORD_W != 2*HALF_W) begin : g_bad_word
         $error("two_word_load_buffer: word width mismatch");
      end
   endgenerate
endmodule

// File: rtl/two_word_load_buffer_chk.sv
module two_word_load_buffer_chk #(
   parameter int unsigned HALF_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                host_ready,
   input logic [2*HALF_W-1:0] word_out,
   input logic                word_full,
   input logic                take_ack
);
   always @(posedge clk) begin
      if (!rst_n) begin
         AST_RESET_EMPTY: assert (host_ready && !word_full && word_out == '0); // R7
      end
   end

   AST_TAKE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      (word_full && take_ack) |=> (host_ready && !word_full)); // R6

   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (word_full && !take_ack) |=> word_full); // R8

   AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (word_full && !take_ack) |=> $stable(word_out)); // R8

   AST_FULL_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(word_full) |-> $past(host_ready)); // R5

   AST_EMPTY_ACK_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
      (!word_full && take_ack) |=> host_ready); // R10
endmodule

bind two_word_load_buffer two_word_load_buffer_chk #(.HALF_W(HALF_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_ready (host_ready),
   .word_out   (word_out),
   .word_full  (word_full),
   .take_ack   (take_ack)
);

// File: tb/two_word_load_buffer_test.sv
module two_word_load_buffer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] host_data = '0;
   logic        host_sel = 1'b0;
   logic        host_wr_n = 1'b1;
   logic        host_ready;
   logic [31:0] word_out;
   logic        word_full;
   logic        take_ack = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   two_word_load_buffer uut (
      .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_sel(host_sel),
      .host_wr_n(host_wr_n), .host_ready(host_ready), .word_out(word_out),
      .word_full(word_full), .take_ack(take_ack)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_state(input string req, input logic [31:0] w, input logic f);
      check(req, word_out, w);
      check(req, {31'd0, word_full}, {31'd0, f});
      check(req, {31'd0, host_ready}, {31'd0, ~f});
   endtask

   task automatic host_write(input logic sel, input logic [15:0] d);
      @(negedge clk);
      host_data = d; host_sel = sel; host_wr_n = 1'b0;
      repeat (3) @(negedge clk);
      host_wr_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic take();
      @(negedge clk); take_ack = 1'b1;
      @(negedge clk); take_ack = 1'b0;
   endtask

   task automatic t_reset();
      check_state("R7 reset", 32'h0, 1'b0);
   endtask

   task automatic t_normal_order();
      host_write(1'b1, 16'hA1B2);
      check_state("R1 low half", 32'h0000_A1B2, 1'b0);
      check_state("R4 one half only", 32'h0000_A1B2, 1'b0);
      host_write(1'b0, 16'hC3D4);
      check_state("R2/R5 high half full", 32'hC3D4_A1B2, 1'b1);
   endtask

   task automatic t_ignored_write();
      host_write(1'b1, 16'hFFFF);
      host_write(1'b0, 16'hEEEE);
      check_state("R8 write while full", 32'hC3D4_A1B2, 1'b1);
   endtask

   task automatic t_take();
      take();
      check_state("R6 after take", 32'hC3D4_A1B2, 1'b0);
      host_write(1'b1, 16'h1111);
      check_state("R6 one half after take", 32'hC3D4_1111, 1'b0);
   endtask

   task automatic t_reverse_order();
      host_write(1'b0, 16'h2222);
      check_state("R5 reverse order", 32'h2222_1111, 1'b1);
      take();
   endtask

   task automatic t_empty_ack();
      take();
      repeat (2) @(negedge clk);
      check_state("R10 ack when empty", 32'h2222_1111, 1'b0);
   endtask

   task automatic t_rewrite_same();
      host_write(1'b0, 16'h3333);
      host_write(1'b0, 16'h4444);
      check_state("R9 rewrite high", 32'h4444_1111, 1'b0);
      host_write(1'b1, 16'h5555);
      check_state("R9 then low", 32'h4444_5555, 1'b1);
      take();
   endtask

   task automatic t_long_pulse();
      @(negedge clk);
      host_data = 16'h6666; host_sel = 1'b1; host_wr_n = 1'b0;
      repeat (10) @(negedge clk);
      check_state("R3 no load while low", 32'h4444_5555, 1'b0);
      host_wr_n = 1'b1;
      repeat (4) @(negedge clk);
      check_state("R3 load after rise", 32'h4444_6666, 1'b0);
      host_data = 16'h7777;
      repeat (6) @(negedge clk);
      check_state("R3 single load", 32'h4444_6666, 1'b0);
   endtask

   task automatic t_reset_mid();
      host_write(1'b0, 16'h8888);
      check_state("R2 before reset", 32'h8888_6666, 1'b1);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check_state("R7 reset clears", 32'h0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_normal_order();
      t_ignored_write();
      t_take();
      t_reverse_order();
      t_empty_ack();
      t_rewrite_same();
      t_long_pulse();
      t_reset_mid();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule